// File: doc/BRIEF.md
# Priority Interrupt Level Resolver

This block decides whether the processor core should see a hard interrupt request and, if it should, which trap type to present. It merges a vector of external interrupt levels with the software-interrupt register. The two timer-match bits in that register are not levels of their own. Either of them raises level 14 instead.

The block compares the merged mask with the current processor interrupt level and picks the highest pending level above it. It then turns that level into an external-interrupt trap type in the range 0x41 to 0x4F. The result goes into a request flag and a trap-type register, which the core samples.

The resolver evaluates again on every clock. It stays silent while a vector interrupt is outstanding. It also declines to raise a new external level while a higher external trap is already being handled at a nonzero trap level.

Top module: `pil_resolver`

## Requirements
- R1: While `rst_n` is low at a clock edge, `irq_req` becomes 0 and `irq_tt` becomes 0 after that edge.
- R2: The pending mask is `ext_lvl` ORed with `soft_int[15:1]` at matching bit positions. Soft bit 0 (tick match) and soft bit 16 (system-tick match) never act as levels 0 or 16.
- R3: If `soft_int[0]` or `soft_int[16]` is set, level 14 counts as pending.
- R4: While `vec_busy` is high at an edge, `irq_req` and `irq_tt` keep their previous values after that edge.
- R5: With `vec_busy` low, if the pending mask, read as an unsigned number, is less than 2 shifted left by `cur_pil`, the next edge sets `irq_req` to 0 and `irq_tt` to 0. With `cur_pil` = 15 this always applies.
- R6: With `vec_busy` low, `int_en` high, something pending above `cur_pil`, and no nesting block (R7), the next edge sets `irq_req` to 1. It sets `irq_tt` to 0x40 ORed with the highest pending level that is above `cur_pil`.
- R7: A nesting block applies when `trap_lvl` is nonzero, `trap_type_cur & 0x1F0` equals 0x40, and `trap_type_cur` is greater than the new trap type. While it applies, the outputs keep their previous values.
- R8: With `vec_busy` low, `int_en` low, and something pending above `cur_pil`, the next edge sets `irq_req` to 0 and `irq_tt` to 0.
- R9: No nesting block applies when `trap_lvl` is 0, when `trap_type_cur` lies outside the 0x40 to 0x4F group, or when `trap_type_cur` equals the new trap type.
- R10: `irq_req` is high exactly when `irq_tt` is nonzero. A nonzero `irq_tt` always lies in the range 0x41 to 0x4F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_lvl | input | 16 | External interrupt level requests, bit n is level n |
| soft_int | input | 17 | Software-interrupt register; bit 0 tick match, bit 16 system-tick match |
| cur_pil | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Global interrupt enable |
| vec_busy | input | 1 | A vector interrupt is outstanding |
| trap_lvl | input | 3 | Current trap level |
| trap_type_cur | input | 9 | Trap type stored at the current trap level |
| irq_req | output | 1 | Registered hard-interrupt request |
| irq_tt | output | 9 | Registered trap type of the request, 0 when idle |

## Verification
The first sweep pairs every processor level with every single external level. It separates the strict "above the current level" threshold from an off-by-one at the boundary.

A second sweep sets one software bit at a time. It shows that ordinary soft bits behave like external levels, and that both timer bits land on level 14 and nowhere else.

Directed nesting cases do the following:
- They place the in-service trap type inside and outside the external group.
- They run at trap level zero and above it.
- They include the case where the in-service type equals the new type.

Together these show which of the three conditions the block depends on. A long pseudo-random run then mixes vector-busy, disable and level changes against a model that tracks the registered state. That run exposes wrong hold versus clear behaviour.

// File: rtl/pil_pkg.sv
package pil_pkg;
    // Shared geometry and encodings of the interrupt level resolver.
    localparam int LEVELS     = 16;
    localparam int PIL_W      = 4;
    localparam int SOFT_W     = 17;
    localparam int TT_W       = 9;
    localparam int TL_W       = 3;
    localparam int TICK_BIT   = 0;
    localparam int STICK_BIT  = 16;
    localparam int TIMER_LVL  = 14;
    localparam logic [TT_W-1:0] EXT_BASE   = 9'h040;
    localparam logic [TT_W-1:0] GROUP_MASK = 9'h1F0;
endpackage

// File: rtl/pil_pending_merge.sv
// Merges external levels with the software-interrupt register into one
// pending mask and reports whether anything lies above the current level.
// Assumes SOFT_W > LEVELS so the system-tick bit sits above the level range.
module pil_pending_merge
    import pil_pkg::*;
#(
    parameter int N_LVL   = LEVELS,
    parameter int S_W     = SOFT_W,
    parameter int P_W     = PIL_W,
    parameter int T_BIT   = TICK_BIT,
    parameter int ST_BIT  = STICK_BIT,
    parameter int TMR_LVL = TIMER_LVL
) (
    input  logic [N_LVL-1:0] ext_lvl,
    input  logic [S_W-1:0]   soft_int,
    input  logic [P_W-1:0]   cur_pil,
    output logic [N_LVL-1:0] pending,
    output logic             above
);
    localparam int CMP_W = N_LVL + 1;

    logic [N_LVL-1:0] merged;
    logic             timer_hit;
    logic [CMP_W-1:0] threshold;

    // Per-bit merge; timer-match positions contribute no level of their own.
    for (genvar g = 0; g < N_LVL; g++) begin : g_bit
        if (g == T_BIT || g == ST_BIT) begin : g_timer
            assign merged[g] = ext_lvl[g];
        end else begin : g_plain
            assign merged[g] = ext_lvl[g] | soft_int[g];
        end
    end

    assign timer_hit = soft_int[T_BIT] | soft_int[ST_BIT];

    // Fold timer matches into their level.
    always_comb begin
        pending          = merged;
        pending[TMR_LVL] = merged[TMR_LVL] | timer_hit;
    end

    // Something is pending strictly above cur_pil when mask >= 2 << cur_pil.
    assign threshold = CMP_W'(2) << cur_pil;
    assign above     = {1'b0, pending} >= threshold;
endmodule

// File: rtl/pil_level_pick.sv
// Priority encoder: finds the highest pending level strictly above the
// current processor level. Assumes level 0 is never a valid request.
module pil_level_pick
    import pil_pkg::*;
#(
    parameter int N_LVL = LEVELS,
    parameter int P_W   = PIL_W,
    localparam int LW   = $clog2(N_LVL)
) (
    input  logic [N_LVL-1:0] pending,
    input  logic [P_W-1:0]   cur_pil,
    output logic [LW-1:0]    level,
    output logic             found
);
    // Ascending scan; the last hit is the highest level.
    always_comb begin
        level = '0;
        found = 1'b0;
        for (int i = 1; i < N_LVL; i++) begin
            if (pending[i] && (i > int'(cur_pil))) begin
                level = LW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pil_nest_guard.sv
// Decides whether a new external trap type must wait behind a higher
// external trap already in service. Assumes trap level 0 means no trap.
module pil_nest_guard
    import pil_pkg::*;
#(
    parameter int T_W  = TT_W,
    parameter int L_W  = TL_W,
    parameter logic [T_W-1:0] BASE = EXT_BASE,
    parameter logic [T_W-1:0] GMASK = GROUP_MASK
) (
    input  logic [L_W-1:0] trap_lvl,
    input  logic [T_W-1:0] trap_type_cur,
    input  logic [T_W-1:0] new_tt,
    output logic           block
);
    logic in_trap, in_group, outranks;

    // Three conditions that all must hold for a block.
    always_comb begin
        in_trap  = trap_lvl != '0;
        in_group = (trap_type_cur & GMASK) == BASE;
        outranks = trap_type_cur > new_tt;
        block    = in_trap && in_group && outranks;
    end
endmodule

// File: rtl/pil_resolver.sv
// Top of the interrupt level resolver. Combines the merge, pick and nest
// guard and holds the request and trap type in registers that update every
// clock unless a vector interrupt is outstanding. Invariant kept: request
// is high exactly when the stored trap type is nonzero.
module pil_resolver
    import pil_pkg::*;
#(
    parameter int N_LVL = LEVELS,
    parameter int S_W   = SOFT_W,
    parameter int P_W   = PIL_W,
    parameter int T_W   = TT_W,
    parameter int L_W   = TL_W,
    parameter logic [T_W-1:0] BASE  = EXT_BASE,
    parameter logic [T_W-1:0] GMASK = GROUP_MASK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_LVL-1:0] ext_lvl,
    input  logic [S_W-1:0]   soft_int,
    input  logic [P_W-1:0]   cur_pil,
    input  logic             int_en,
    input  logic             vec_busy,
    input  logic [L_W-1:0]   trap_lvl,
    input  logic [T_W-1:0]   trap_type_cur,
    output logic             irq_req,
    output logic [T_W-1:0]   irq_tt
);
    localparam int LW = $clog2(N_LVL);

    logic [N_LVL-1:0] pending;
    logic             above;
    logic [LW-1:0]    level;
    logic             found;
    logic [T_W-1:0]   new_tt;
    logic             block;
    logic             req_q;
    logic [T_W-1:0]   tt_q;

    pil_pending_merge #(
        .N_LVL(N_LVL), .S_W(S_W), .P_W(P_W),
        .T_BIT(TICK_BIT), .ST_BIT(STICK_BIT), .TMR_LVL(TIMER_LVL)
    ) u_merge (
        .ext_lvl(ext_lvl), .soft_int(soft_int), .cur_pil(cur_pil),
        .pending(pending), .above(above)
    );

    pil_level_pick #(.N_LVL(N_LVL), .P_W(P_W)) u_pick (
        .pending(pending), .cur_pil(cur_pil), .level(level), .found(found)
    );

    assign new_tt = BASE | T_W'(level);

    pil_nest_guard #(.T_W(T_W), .L_W(L_W), .BASE(BASE), .GMASK(GMASK)) u_guard (
        .trap_lvl(trap_lvl), .trap_type_cur(trap_type_cur),
        .new_tt(new_tt), .block(block)
    );

    // Request and trap-type state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            tt_q  <= '0;
        end else if (!vec_busy) begin
            if (!above) begin
                req_q <= 1'b0;
                tt_q  <= '0;
            end else if (int_en) begin
                if (!block && found && (tt_q != new_tt)) begin
                    req_q <= 1'b1;
                    tt_q  <= new_tt;
                end
            end else if (req_q) begin
                req_q <= 1'b0;
                tt_q  <= '0;
            end
        end
    end

    assign irq_req = req_q;
    assign irq_tt  = tt_q;

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_busy |=> ($stable(irq_req) && $stable(irq_tt)));

    // R5
    below_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_busy && !above) |=> (!irq_req && irq_tt == '0));

    // R6
    raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_busy && above && int_en && !block) |=>
            (irq_req && irq_tt == $past(new_tt)));

    // R7
    nest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_busy && above && int_en && block) |=>
            ($stable(irq_req) && $stable(irq_tt)));

    // R8
    disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_busy && above && !int_en) |=> (!irq_req && irq_tt == '0));

    // R10
    req_tt_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (irq_tt != '0));

    // R10
    tt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((irq_tt & GMASK) == BASE && irq_tt != BASE));
endmodule

// File: tb/pil_resolver_tb.sv
module pil_resolver_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ext_lvl = '0;
    logic [16:0] soft_int = '0;
    logic [3:0]  cur_pil = '0;
    logic        int_en = 1'b0;
    logic        vec_busy = 1'b0;
    logic [2:0]  trap_lvl = '0;
    logic [8:0]  trap_type_cur = '0;
    logic        irq_req;
    logic [8:0]  irq_tt;

    int checks = 0;
    int errors = 0;
    logic       exp_req = 1'b0;
    logic [8:0] exp_tt = '0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #4 clk = ~clk;

    pil_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .ext_lvl(ext_lvl), .soft_int(soft_int),
        .cur_pil(cur_pil), .int_en(int_en), .vec_busy(vec_busy),
        .trap_lvl(trap_lvl), .trap_type_cur(trap_type_cur),
        .irq_req(irq_req), .irq_tt(irq_tt)
    );

    function automatic logic [31:0] rnd(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (irq_req !== exp_req || irq_tt !== exp_tt) begin
            errors++;
            $display("FAIL %s: req=%0b tt=%h expected req=%0b tt=%h",
                     tag, irq_req, irq_tt, exp_req, exp_tt);
        end
    endtask

    // Expected next state from the requirements; returns the governing tag.
    task automatic model(output string rule);
        logic [15:0] p;
        logic [8:0]  ntt;
        int          lvl;
        p = ext_lvl | (soft_int[15:0] & 16'hFFFE);
        if (soft_int[0] || soft_int[16]) p[14] = 1'b1;
        if (vec_busy) begin
            rule = "R4";
        end else if ({1'b0, p} < (17'd2 << cur_pil)) begin
            rule = "R5"; exp_req = 1'b0; exp_tt = '0;
        end else if (int_en) begin
            lvl = 0;
            for (int i = 15; i > int'(cur_pil); i--)
                if (p[i] && lvl == 0) lvl = i;
            ntt = 9'h040 | 9'(lvl);
            if (trap_lvl != 0 && trap_type_cur > ntt &&
                (trap_type_cur & 9'h1F0) == 9'h040) begin
                rule = "R7";
            end else begin
                rule = "R6";
                if (exp_tt != ntt) begin exp_req = 1'b1; exp_tt = ntt; end
            end
        end else begin
            rule = "R8"; exp_req = 1'b0; exp_tt = '0;
        end
    endtask

    task automatic apply(input string hint);
        string rule;
        model(rule);
        @(negedge clk);
        compare({hint, "/", rule});
    endtask

    task automatic set_in(input logic [15:0] e, input logic [16:0] s,
                          input logic [3:0] p, input logic ie, input logic vb,
                          input logic [2:0] tl, input logic [8:0] ct);
        ext_lvl = e; soft_int = s; cur_pil = p; int_en = ie;
        vec_busy = vb; trap_lvl = tl; trap_type_cur = ct;
    endtask

    task automatic do_reset();
        set_in(16'hFFFF, 17'h1FFFF, 4'd0, 1'b1, 1'b0, 3'd0, 9'd0);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        exp_req = 1'b0; exp_tt = '0;
        compare("R1");
        rst_n = 1'b1;
        set_in(16'h0, 17'h0, 4'd0, 1'b1, 1'b0, 3'd0, 9'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // Every processor level against every single external level (R5, R6).
        for (int p = 0; p < 16; p++) begin
            for (int l = 1; l < 16; l++) begin
                set_in(16'h0, 17'h0, 4'(p), 1'b1, 1'b0, 3'd0, 9'd0);
                apply("R5");
                set_in(16'(1 << l), 17'h0, 4'(p), 1'b1, 1'b0, 3'd0, 9'd0);
                apply("R6");
            end
        end

        // All levels pending: highest wins, pil 15 stays idle.
        for (int p = 0; p < 16; p++) begin
            set_in(16'hFFFF, 17'h0, 4'(p), 1'b1, 1'b0, 3'd0, 9'd0);
            apply("R6");
        end

        // One soft bit at a time (R2 plain bits, R3 timer bits -> level 14).
        for (int b = 0; b < 17; b++) begin
            set_in(16'h0, 17'h0, 4'd0, 1'b1, 1'b0, 3'd0, 9'd0);
            apply("R5");
            set_in(16'h0, 17'(1 << b), 4'd0, 1'b1, 1'b0, 3'd0, 9'd0);
            apply((b == 0 || b == 16) ? "R3" : "R2");
        end
        // Timer bit with pil 14 gives nothing above (R3 boundary).
        set_in(16'h0, 17'h10000, 4'd14, 1'b1, 1'b0, 3'd0, 9'd0);
        apply("R3");

        // Nesting block and its exceptions (R7, R9).
        set_in(16'h0020, 17'h0, 4'd0, 1'b1, 1'b0, 3'd0, 9'd0);
        apply("R6");
        set_in(16'h0008, 17'h0, 4'd0, 1'b1, 1'b0, 3'd1, 9'h04A);
        apply("R7");
        set_in(16'h0008, 17'h0, 4'd0, 1'b1, 1'b0, 3'd0, 9'h04A);
        apply("R9");
        set_in(16'h0020, 17'h0, 4'd0, 1'b1, 1'b0, 3'd0, 9'd0);
        apply("R6");
        set_in(16'h0008, 17'h0, 4'd0, 1'b1, 1'b0, 3'd2, 9'h05A);
        apply("R9");
        set_in(16'h0020, 17'h0, 4'd0, 1'b1, 1'b0, 3'd0, 9'd0);
        apply("R6");
        set_in(16'h0008, 17'h0, 4'd0, 1'b1, 1'b0, 3'd1, 9'h043);
        apply("R9");

        // Disable withdraws a live request (R8), then busy holds (R4).
        set_in(16'h0100, 17'h0, 4'd0, 1'b1, 1'b0, 3'd0, 9'd0);
        apply("R6");
        set_in(16'h0100, 17'h0, 4'd0, 1'b0, 1'b0, 3'd0, 9'd0);
        apply("R8");
        set_in(16'h0100, 17'h0, 4'd0, 1'b1, 1'b0, 3'd0, 9'd0);
        apply("R6");
        set_in(16'h8000, 17'h0, 4'd0, 1'b1, 1'b1, 3'd0, 9'd0);
        apply("R4");
        set_in(16'h0000, 17'h0, 4'd0, 1'b0, 1'b1, 3'd0, 9'd0);
        apply("R4");

        // Pseudo-random mix against the model (R10 consistency alongside).
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] a, b;
            lfsr = rnd(lfsr); a = lfsr;
            lfsr = rnd(lfsr); b = lfsr;
            set_in(a[15:0] & b[31:16], (a[3:0] == 0) ? b[16:0] : 17'(b[0]) << 16,
                   a[19:16], a[22:20] != 0, a[26:24] == 0,
                   a[27] ? b[19:17] : 3'd0,
                   a[28] ? (9'h040 | 9'(b[23:20])) : b[28:20]);
            apply("R10");
            if (n == 2000) do_reset();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule